// File: doc/BRIEF.md
# 1-Wire Bit Slot Timing Engine

This block is the timing core of a single-line open-drain bus master. On request it runs one of three self-contained bus operations: a bus reset that also listens for a presence response, a slot that writes a zero, and a slot that writes a one while sampling the line. The last of these is also how a bit is read. Byte assembly, device search and the pad cell stay outside the block. The block has one output that pulls the line low. Releasing that output lets the external pull-up raise the line, and nothing in the block ever drives the line high. The line level comes back on `line_in` and passes through a two-flop synchroniser.

Time is measured in microsecond units. A prescaler set by `CLK_PER_US` derives each unit from the system clock. A runtime coefficient on `delay_coef` stretches every unit: a phase of N microseconds lasts N × coef × `CLK_PER_US` clock cycles. A coefficient of zero counts as one. The coefficient is captured when a command is accepted.

The controller is a state machine with nine states. `ST_IDLE` accepts a command and moves to one of three first phases:
- `ST_RST_LOW` when `cmd_reset` is 1.
- `ST_RD_LOW` when `cmd_bit` is 1.
- `ST_W0_LOW` otherwise.

Each phase moves on when its timer expires:
- Reset: `ST_RST_LOW` → `ST_RST_WAIT` → `ST_RST_REC` → `ST_IDLE`. The line is sampled on leaving `ST_RST_WAIT`.
- Write-0: `ST_W0_LOW` → `ST_W0_REC` → `ST_IDLE`.
- Write-1 / read: `ST_RD_LOW` → `ST_RD_WAIT` → `ST_RD_REC` → `ST_IDLE`. The line is sampled on leaving `ST_RD_WAIT`.

Top module: `owire_slot_engine`

## Requirements
- R1: After reset, `line_drive_low`, `busy`, `done`, `rx_bit` and `presence` are all 0.
- R2: A slot with `cmd_bit`=1 pulls the line low for 6 units, releases it, samples 9 units after release, and ends 55 units later (70 units in total).
- R3: A slot with `cmd_bit`=0 pulls the line low for 60 units and then releases it for 10 units. On completion, `rx_bit` becomes 0.
- R4: A reset (`cmd_reset`=1) pulls the line low for 480 units, releases it, samples 70 units after release, and ends after a further 410 units (960 units in total).
- R5: On completion of a reset, `presence` becomes 1 if the sampled level was low and 0 if it was high. `presence` changes at no other time.
- R6: On completion of a `cmd_bit`=1 slot, `rx_bit` takes the sampled line level. `rx_bit` changes only in a `done` cycle.
- R7: One unit is `delay_coef` × `CLK_PER_US` cycles, with a coefficient of 0 treated as 1. The coefficient is captured at acceptance, and later changes do not affect the running operation.
- R8: A command is accepted only at a clock edge where `busy` is 0 and `cmd_valid` is 1. `busy` rises in the cycle after acceptance and stays high until the operation ends. Commands presented while busy are ignored.
- R9: `done` is high for exactly one cycle, the first cycle with `busy` low after an operation. A command may be accepted in that cycle.
- R10: The sampled level is the level `line_in` had in the clock cycle three cycles before the sampling edge, because of the two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_reset | input | 1 | 1: bus reset with presence detect; 0: bit slot |
| cmd_bit | input | 1 | Slot data: 1 = write-1/read slot, 0 = write-0 slot |
| delay_coef | input | COEF_W | Timing multiplier, 0 behaves as 1 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Level sampled by the last read slot (0 after write-0) |
| presence | output | 1 | 1 if a device answered the last reset |
| line_drive_low | output | 1 | 1 pulls the bus line low; 0 releases it |
| line_in | input | 1 | Asynchronous bus line level |

## Verification
The bench targets the exact sampling instant. It has a device pull the line low either only two cycles before the sampling edge or exactly three cycles before it. A design with the wrong synchroniser depth, or one that samples a phase early or late, returns the wrong bit. It changes `delay_coef` in the middle of a slot and uses a coefficient of zero. A design that does not freeze the coefficient, or that turns zero into an endless phase, then shows a low pulse of the wrong length cycle by cycle. It presents commands during a reset and holds a command valid across the `done` cycle. This catches a design that restarts while busy and one that delays the back-to-back acceptance by a cycle. It also checks that a write-0 clears `rx_bit` while a reset leaves it unchanged.

// File: rtl/owire_pkg.sv
package owire_pkg;

    localparam int UNIT_W = 9;

    localparam int T_RST_LOW  = 480;
    localparam int T_RST_WAIT = 70;
    localparam int T_RST_REC  = 410;
    localparam int T_W0_LOW   = 60;
    localparam int T_W0_REC   = 10;
    localparam int T_RD_LOW   = 6;
    localparam int T_RD_WAIT  = 9;
    localparam int T_RD_REC   = 55;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_RST_REC,
        ST_W0_LOW,
        ST_W0_REC,
        ST_RD_LOW,
        ST_RD_WAIT,
        ST_RD_REC
    } phase_e;

    function automatic logic [UNIT_W-1:0] phase_len(input phase_e p);
        logic [UNIT_W-1:0] r;
        unique case (p)
            ST_RST_LOW:  r = UNIT_W'(T_RST_LOW);
            ST_RST_WAIT: r = UNIT_W'(T_RST_WAIT);
            ST_RST_REC:  r = UNIT_W'(T_RST_REC);
            ST_W0_LOW:   r = UNIT_W'(T_W0_LOW);
            ST_W0_REC:   r = UNIT_W'(T_W0_REC);
            ST_RD_LOW:   r = UNIT_W'(T_RD_LOW);
            ST_RD_WAIT:  r = UNIT_W'(T_RD_WAIT);
            ST_RD_REC:   r = UNIT_W'(T_RD_REC);
            default:     r = UNIT_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/owire_sync2.sv
module owire_sync2 #(
    parameter int  STAGES   = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/owire_us_tick.sv
module owire_us_tick #(
    parameter int CLK_PER_US = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/owire_phase_timer.sv
module owire_phase_timer
    import owire_pkg::*;
#(
    parameter int COEF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [UNIT_W-1:0] units,
    input  logic [COEF_W-1:0] coef_m1,
    output logic              expire
);
    logic [COEF_W-1:0] sub_q;
    logic [UNIT_W-1:0] remain_q;
    logic              unit_end;

    assign unit_end = tick && (sub_q == coef_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q    <= '0;
            remain_q <= '0;
        end else if (start) begin
            sub_q    <= '0;
            remain_q <= units;
        end else if (tick) begin
            if (sub_q == coef_m1) begin
                sub_q <= '0;
                if (remain_q != '0) begin
                    remain_q <= remain_q - 1'b1;
                end
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign expire = unit_end && (remain_q == UNIT_W'(1));
endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
    import owire_pkg::*;
#(
    parameter int CLK_PER_US = 250,
    parameter int COEF_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_reset,
    input  logic              cmd_bit,
    input  logic [COEF_W-1:0] delay_coef,
    output logic              busy,
    output logic              done,
    output logic              rx_bit,
    output logic              presence,
    output logic              line_drive_low,
    input  logic              line_in
);
    phase_e            state_q, state_d;
    logic [COEF_W-1:0] coef_q;
    logic [COEF_W-1:0] coef_m1;
    logic [UNIT_W-1:0] len_d;
    logic              line_s;
    logic              us_tick;
    logic              expire;
    logic              phase_start;
    logic              accept;
    logic              samp_q;
    logic              done_q;
    logic              rx_q;
    logic              pres_q;

    owire_sync2 #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (line_s)
    );

    owire_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (phase_start),
        .tick  (us_tick)
    );

    owire_phase_timer #(.COEF_W(COEF_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (phase_start),
        .tick    (us_tick),
        .units   (len_d),
        .coef_m1 (coef_m1),
        .expire  (expire)
    );

    assign accept      = (state_q == ST_IDLE) && cmd_valid;
    assign coef_m1     = (coef_q == '0) ? '0 : coef_q - COEF_W'(1);
    assign len_d       = phase_len(state_d);
    assign phase_start = (state_d != state_q) && (state_d != ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_reset)    state_d = ST_RST_LOW;
                    else if (cmd_bit) state_d = ST_RD_LOW;
                    else              state_d = ST_W0_LOW;
                end
            end
            ST_RST_LOW:  if (expire) state_d = ST_RST_WAIT;
            ST_RST_WAIT: if (expire) state_d = ST_RST_REC;
            ST_RST_REC:  if (expire) state_d = ST_IDLE;
            ST_W0_LOW:   if (expire) state_d = ST_W0_REC;
            ST_W0_REC:   if (expire) state_d = ST_IDLE;
            ST_RD_LOW:   if (expire) state_d = ST_RD_WAIT;
            ST_RD_WAIT:  if (expire) state_d = ST_RD_REC;
            ST_RD_REC:   if (expire) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured coefficient, sample and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_q <= '0;
            samp_q <= 1'b1;
            done_q <= 1'b0;
            rx_q   <= 1'b0;
            pres_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                coef_q <= delay_coef;
            end
            if (expire) begin
                unique case (state_q)
                    ST_RST_WAIT, ST_RD_WAIT: samp_q <= line_s;
                    ST_RST_REC: begin
                        done_q <= 1'b1;
                        pres_q <= ~samp_q;
                    end
                    ST_W0_REC: begin
                        done_q <= 1'b1;
                        rx_q   <= 1'b0;
                    end
                    ST_RD_REC: begin
                        done_q <= 1'b1;
                        rx_q   <= samp_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        busy           = (state_q != ST_IDLE);
        line_drive_low = (state_q == ST_RST_LOW) || (state_q == ST_W0_LOW) ||
                         (state_q == ST_RD_LOW);
        done           = done_q;
        rx_bit         = rx_q;
        presence       = pres_q;
    end
endmodule

// File: rtl/owire_slot_checker.sv
module owire_slot_checker #(
    parameter int COEF_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rx_bit,
    input logic              presence,
    input logic              line_drive_low,
    input logic [COEF_W-1:0] coef_q
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_drive_in_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_drive_low |-> busy);

    assert_coef_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(coef_q));

    assert_presence_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(presence) |-> done);

    assert_rx_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_bit) |-> done);
endmodule

bind owire_slot_engine owire_slot_checker #(.COEF_W(COEF_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .done           (done),
    .rx_bit         (rx_bit),
    .presence       (presence),
    .line_drive_low (line_drive_low),
    .coef_q         (coef_q)
);

// File: tb/owire_slot_engine_tb_top.sv
`timescale 1ns/1ps
module owire_slot_engine_tb_top;
    localparam int CPU    = 4;
    localparam int COEF_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_reset = 1'b0;
    logic              cmd_bit = 1'b0;
    logic [COEF_W-1:0] delay_coef = COEF_W'(1);
    logic              busy, done, rx_bit, presence, line_drive_low;
    logic              dev_low = 1'b0;
    logic              line_in;

    assign line_in = !(line_drive_low || dev_low);

    always #2 clk = ~clk;

    owire_slot_engine #(.CLK_PER_US(CPU), .COEF_W(COEF_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_reset      (cmd_reset),
        .cmd_bit        (cmd_bit),
        .delay_coef     (delay_coef),
        .busy           (busy),
        .done           (done),
        .rx_bit         (rx_bit),
        .presence       (presence),
        .line_drive_low (line_drive_low),
        .line_in        (line_in)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    bit    finished = 0;

    // behavioural reference state
    bit    m_active = 0;
    int    m_t = 0, m_low = 0, m_S = 0, m_total = 0, m_kind = 0;
    bit    m_samp = 1, m_rx = 0, m_pres = 0;
    string m_tag = "R1", cur_tag = "R1";
    bit    dev_en = 0;
    int    dlo = 0, dhi = 0;
    int    done_cnt = 0;

    task automatic chk(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: got %b expected %b", tag, what, $time, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin : model
        bit acc;
        bit dexp;
        int k;
        int u;
        #1;
        if (rst_n && !finished) begin
            acc  = cmd_valid && !m_active;
            dexp = 0;
            if (m_active) begin
                m_t++;
                if (m_t == m_total) begin
                    m_active = 0;
                    dexp = 1;
                    done_cnt++;
                    if (m_kind == 0)      m_rx = m_samp;
                    else if (m_kind == 1) m_rx = 0;
                    else                  m_pres = !m_samp;
                end
            end
            if (acc) begin
                k = (delay_coef == 0) ? 1 : int'(delay_coef);
                u = k * CPU;
                if (cmd_reset) begin
                    m_kind = 2; m_low = 480*u; m_S = 550*u; m_total = 960*u;
                end else if (cmd_bit) begin
                    m_kind = 0; m_low = 6*u; m_S = 15*u; m_total = 70*u;
                end else begin
                    m_kind = 1; m_low = 60*u; m_S = -100; m_total = 70*u;
                end
                m_t = 0;
                m_active = 1;
                m_tag = cur_tag;
            end
            dev_low = dev_en && m_active && (m_t >= m_S + dlo) && (m_t <= m_S + dhi);
            if (m_active && m_t == m_S - 3) m_samp = !line_drive_low && !dev_low;
            chk(m_tag, "line_drive_low", line_drive_low, m_active && (m_t < m_low));
            chk("R8", "busy", busy, m_active);
            chk("R9", "done", done, dexp);
            chk(m_tag, "rx_bit", rx_bit, m_rx);
            chk(m_tag, "presence", presence, m_pres);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    task automatic run_op(bit is_rst, bit b, int c, string tag, bit den, int lo, int hi);
        @(negedge clk);
        cur_tag = tag; dev_en = den; dlo = lo; dhi = hi;
        delay_coef = COEF_W'(c); cmd_reset = is_rst; cmd_bit = b; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        while (m_active) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "done", done, 1'b0);
        chk("R1", "line_drive_low", line_drive_low, 1'b0);
        chk("R1", "rx_bit", rx_bit, 1'b0);
        chk("R1", "presence", presence, 1'b0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        run_op(0, 1, 1, "R2", 0, 0, 0);      // read, silent line -> 1
        run_op(0, 0, 1, "R3", 0, 0, 0);      // write-0 clears rx_bit
        run_op(0, 1, 1, "R6", 1, -20, 20);   // read, device holds low -> 0
        run_op(0, 1, 1, "R6", 0, 0, 0);      // read back to 1
        run_op(1, 0, 1, "R4", 1, -200, 100); // reset with device -> presence
        run_op(1, 0, 1, "R5", 0, 0, 0);      // reset, no device
        run_op(1, 0, 1, "R5", 1, -200, 100); // presence again
        run_op(0, 1, 2, "R7", 0, 0, 0);      // coef 2
        run_op(0, 0, 0, "R7", 0, 0, 0);      // coef 0 acts as 1
        run_op(0, 1, 1, "R10", 1, -2, -1);   // low too late for synchroniser -> 1
        run_op(0, 1, 1, "R10", 1, -3, -3);   // low exactly at the sampled cycle -> 0

        // R7: coefficient changed during an operation
        @(negedge clk);
        cur_tag = "R7"; dev_en = 0;
        delay_coef = COEF_W'(3); cmd_reset = 0; cmd_bit = 1; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        repeat (10) @(negedge clk);
        delay_coef = COEF_W'(1);
        while (m_active) @(negedge clk);
        @(negedge clk);

        // R8: commands presented while busy are ignored
        @(negedge clk);
        cur_tag = "R8"; dev_en = 0; delay_coef = COEF_W'(1);
        cmd_reset = 1; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0; cmd_reset = 0; cmd_bit = 0;
        repeat (100) @(negedge clk);
        cmd_valid = 1;
        repeat (5) @(negedge clk);
        cmd_valid = 0;
        while (m_t != m_total - 2) @(negedge clk);
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        while (m_active) @(negedge clk);
        @(negedge clk);

        // R9: command held valid is taken again in the done cycle
        @(negedge clk);
        cur_tag = "R9"; dev_en = 0; cmd_reset = 0; cmd_bit = 1; cmd_valid = 1;
        d0 = done_cnt;
        @(negedge clk);
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
        while (m_active) @(negedge clk);
        repeat (3) @(negedge clk);

        finished = 1;
        summary();
    end
endmodule